// File: doc/BRIEF.md
# Glitch-Free GPIO Bank Restore Sequencer

This block saves and restores the state of one GPIO bank around a low-power period. Each pin of the bank has a mode field of `FIELD_W` bits in a shared configuration word. A field value of 0 makes the pin an input, 1 an output, and any value of 2 or more selects a special function. A save strobe reads the bank's configuration, data and pull-resistor words over a simple register master port and keeps them.

A restore strobe first reads the bank's present configuration. It then classifies every scanned pin by its present and its saved mode, and from that builds a change mask. Pins in the mask get their saved configuration before the data word is written. All other pins get theirs only after the data word. This way no pin drives a stale data value or passes through a mode that is neither its present nor its saved one. Two sequence variants exist, chosen by `FIELD_W`. The 2-bit variant scans every field of the word. The 4-bit variant scans only the four low fields.

Top module: `gpio_restore_seq`

## Requirements
- R1: After reset `busy`, `done` and `bus_req` are low, and the block issues no bus operation while idle.
- R2: A save performs exactly three reads on consecutive cycles, at address 0x00 (configuration), 0x04 (data) and 0x08 (pull resistors) in that order, with no write. `done` is seen on the 4th cycle after the request edge.
- R3: Pin i's mode field sits at configuration bits [i*FIELD_W +: FIELD_W], with pin 0 at bit 0. Value 0 means input, 1 output, and 2 or more special function.
- R4: A scanned pin joins the change mask when it goes input to special function, output to special function, output to input, or special function to input.
- R5: A pin stays out of the mask when its present and saved fields are equal, when both are special functions, or when its saved mode is output and its present mode is input or special function.
- R6: With FIELD_W=2, a restore reads 0x00 and then writes, in this order: the saved pull word to 0x08; to 0x00 the present configuration with the masked fields replaced by saved ones; the saved data to 0x04; and the full saved configuration to 0x00.
- R7: With FIELD_W=4, only fields 0 to 3 are scanned. A restore reads 0x00 and then writes, in this order: the merged configuration to 0x00, saved data to 0x04, saved configuration to 0x00, saved data again to 0x04, and the saved pull word to 0x08.
- R8: During a restore every configuration write gives each pin either its present or its saved field. A masked pin changes mode before the data write. A pin going to output changes mode only after the data write.
- R9: One bus operation is issued per cycle. `done` is a one-cycle pulse on the cycle after the last operation. A restore shows `done` on the 6th (FIELD_W=2) or 7th (FIELD_W=4) cycle after the request edge.
- R10: Save and restore requests are ignored while `busy` is high. When both arrive together while idle, the save is performed.
- R11: Read data on `bus_rdata` is taken in the same cycle as the read request (combinational bank reply).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| save_req | input | 1 | Start a save when idle |
| restore_req | input | 1 | Start a restore when idle |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |
| bus_req | output | 1 | Register operation valid this cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Register byte offset |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid in the request cycle |

## Verification
On every cycle the assertions check the following. The bus is quiet while idle. A save never writes. `done` lasts one cycle. A running sequence is never restarted by a new request. The merged configuration write changes only masked fields. No masked pin has output as its saved mode. Only the bench's scenarios can show that the full write order and data values match the variant. They also show that all nine present/saved mode pairs are classified correctly, and that, replayed pin by pin against the bank model, no pin takes an intermediate mode or changes mode on the wrong side of the data write.

// File: rtl/gpio_rst_pkg.sv
package gpio_rst_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DAT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_PULL = 8'h08;

    typedef enum logic [1:0] {
        CLS_IN,
        CLS_OUT,
        CLS_SFN
    } mode_cls_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_MERGE,
        SRC_CFG,
        SRC_DAT,
        SRC_PULL
    } wsrc_e;

    typedef struct packed {
        logic              act;
        logic              we;
        logic [ADDR_W-1:0] addr;
        wsrc_e             src;
    } bus_op_t;

    function automatic mode_cls_e classify(logic [3:0] f);
        if (f == 4'd0)      return CLS_IN;
        else if (f == 4'd1) return CLS_OUT;
        else                return CLS_SFN;
    endfunction

    // 1 when the pin must take its new mode before the data word lands
    function automatic logic cfg_first(logic [3:0] prev, logic [3:0] next);
        mode_cls_e cp;
        mode_cls_e cn;
        cp = classify(prev);
        cn = classify(next);
        if (prev == next)                       return 1'b0;
        else if (cp == CLS_SFN && cn == CLS_SFN) return 1'b0;
        else if (cn == CLS_OUT)                 return 1'b0;
        else                                    return 1'b1;
    endfunction

    function automatic bus_op_t mk_op(logic we, logic [ADDR_W-1:0] a, wsrc_e s);
        bus_op_t o;
        o.act  = 1'b1;
        o.we   = we;
        o.addr = a;
        o.src  = s;
        return o;
    endfunction

    function automatic bus_op_t save_op(logic [2:0] step);
        case (step)
            3'd0:    return mk_op(1'b0, OFS_CFG, SRC_NONE);
            3'd1:    return mk_op(1'b0, OFS_DAT, SRC_NONE);
            default: return mk_op(1'b0, OFS_PULL, SRC_NONE);
        endcase
    endfunction

    function automatic bus_op_t restore_op(logic wide, logic [2:0] step);
        if (!wide) begin
            case (step)
                3'd0:    return mk_op(1'b0, OFS_CFG, SRC_NONE);
                3'd1:    return mk_op(1'b1, OFS_PULL, SRC_PULL);
                3'd2:    return mk_op(1'b1, OFS_CFG, SRC_MERGE);
                3'd3:    return mk_op(1'b1, OFS_DAT, SRC_DAT);
                default: return mk_op(1'b1, OFS_CFG, SRC_CFG);
            endcase
        end else begin
            case (step)
                3'd0:    return mk_op(1'b0, OFS_CFG, SRC_NONE);
                3'd1:    return mk_op(1'b1, OFS_CFG, SRC_MERGE);
                3'd2:    return mk_op(1'b1, OFS_DAT, SRC_DAT);
                3'd3:    return mk_op(1'b1, OFS_CFG, SRC_CFG);
                3'd4:    return mk_op(1'b1, OFS_DAT, SRC_DAT);
                default: return mk_op(1'b1, OFS_PULL, SRC_PULL);
            endcase
        end
    endfunction

endpackage

// File: rtl/gpio_rst_mask.sv
module gpio_rst_mask
    import gpio_rst_pkg::*;
#(
    parameter int FIELD_W     = 2,
    parameter int DATA_W      = 32,
    parameter int SCAN_FIELDS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] cur_cfg,
    input  logic [DATA_W-1:0] sav_cfg,
    output logic [DATA_W-1:0] mask
);
    localparam int NUM_FIELDS = DATA_W / FIELD_W;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        if (i < SCAN_FIELDS) begin : g_scan
            logic [3:0] prev_f;
            logic [3:0] next_f;
            assign prev_f = 4'(cur_cfg[i*FIELD_W +: FIELD_W]);
            assign next_f = 4'(sav_cfg[i*FIELD_W +: FIELD_W]);
            assign mask[i*FIELD_W +: FIELD_W] = {FIELD_W{cfg_first(prev_f, next_f)}};

            // R5: a pin whose target mode is output never goes first
            a_r5_no_out_target: assert property (@(posedge clk) disable iff (rst)
                mask[i*FIELD_W] |-> (sav_cfg[i*FIELD_W +: FIELD_W] != FIELD_W'(1)));
            // R4: a masked pin always changes its field
            a_r4_masked_changes: assert property (@(posedge clk) disable iff (rst)
                mask[i*FIELD_W] |-> (sav_cfg[i*FIELD_W +: FIELD_W] != cur_cfg[i*FIELD_W +: FIELD_W]));
        end else begin : g_skip
            assign mask[i*FIELD_W +: FIELD_W] = '0;
        end
    end

endmodule

// File: rtl/gpio_rst_ctrl.sv
module gpio_rst_ctrl
    import gpio_rst_pkg::*;
#(
    parameter int FIELD_W = 2,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              save_req,
    input  logic              restore_req,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              done,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] cur_cfg,
    output logic [DATA_W-1:0] sav_cfg
);
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAVE,
        ST_RESTORE
    } st_e;

    localparam logic       WIDE      = (FIELD_W != 2);
    localparam logic [2:0] SAVE_LAST = 3'd2;
    localparam logic [2:0] REST_LAST = WIDE ? 3'd5 : 3'd4;

    st_e               state;
    logic [2:0]        step;
    logic [2:0]        last;
    bus_op_t           op;
    logic [DATA_W-1:0] sav_dat;
    logic [DATA_W-1:0] sav_pull;

    always_comb begin
        case (state)
            ST_SAVE:    op = save_op(step);
            ST_RESTORE: op = restore_op(WIDE, step);
            default:    op = '0;
        endcase
        last = (state == ST_SAVE) ? SAVE_LAST : REST_LAST;
    end

    always_comb begin
        case (op.src)
            SRC_MERGE: bus_wdata = (cur_cfg & ~mask) | (sav_cfg & mask);
            SRC_CFG:   bus_wdata = sav_cfg;
            SRC_DAT:   bus_wdata = sav_dat;
            SRC_PULL:  bus_wdata = sav_pull;
            default:   bus_wdata = '0;
        endcase
    end

    assign busy     = (state != ST_IDLE);
    assign bus_req  = op.act;
    assign bus_we   = op.we;
    assign bus_addr = op.addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            step     <= '0;
            done     <= 1'b0;
            cur_cfg  <= '0;
            sav_cfg  <= '0;
            sav_dat  <= '0;
            sav_pull <= '0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                step <= '0;
                if (save_req)         state <= ST_SAVE;
                else if (restore_req) state <= ST_RESTORE;
            end else begin
                if (op.act && !op.we) begin
                    case (op.addr)
                        OFS_CFG: begin
                            if (state == ST_SAVE) sav_cfg <= bus_rdata;
                            else                  cur_cfg <= bus_rdata;
                        end
                        OFS_DAT:  sav_dat  <= bus_rdata;
                        OFS_PULL: sav_pull <= bus_rdata;
                        default: ;
                    endcase
                end
                if (step == last) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end else begin
                    step <= step + 3'd1;
                end
            end
        end
    end

    // R1: nothing on the bus while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req);
    // R2: a save only reads
    a_r2_save_reads: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SAVE) |-> (bus_req && !bus_we));
    // R9: done lasts exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R10: a running sequence keeps its kind until its last step
    a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && step != last) |=> (state == $past(state)) && (step == $past(step) + 3'd1));
    // R8: the early configuration write touches only masked fields
    a_r8_merge_window: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && op.src == SRC_MERGE) |-> (((bus_wdata ^ cur_cfg) & ~mask) == '0));

endmodule

// File: rtl/gpio_restore_seq.sv
module gpio_restore_seq
    import gpio_rst_pkg::*;
#(
    parameter int FIELD_W = 2,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              save_req,
    input  logic              restore_req,
    output logic              busy,
    output logic              done,
    output logic              bus_req,
    output logic              bus_we,
    output logic [7:0]        bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int SCAN_FIELDS = (FIELD_W == 2) ? (DATA_W / FIELD_W) : 4;

    logic [DATA_W-1:0] cur_cfg;
    logic [DATA_W-1:0] sav_cfg;
    logic [DATA_W-1:0] mask;

    gpio_rst_mask #(
        .FIELD_W    (FIELD_W),
        .DATA_W     (DATA_W),
        .SCAN_FIELDS(SCAN_FIELDS)
    ) u_mask (
        .clk    (clk),
        .rst    (rst),
        .cur_cfg(cur_cfg),
        .sav_cfg(sav_cfg),
        .mask   (mask)
    );

    gpio_rst_ctrl #(
        .FIELD_W(FIELD_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .save_req   (save_req),
        .restore_req(restore_req),
        .mask       (mask),
        .bus_rdata  (bus_rdata),
        .busy       (busy),
        .done       (done),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cur_cfg    (cur_cfg),
        .sav_cfg    (sav_cfg)
    );

    // R9: the block finishes through done, never while still driving the bus
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !bus_req));

endmodule

// File: tb/tb_gpio_restore_seq.sv
module tb_gpio_bank (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        load,
    input  logic [31:0] ld_cfg,
    input  logic [31:0] ld_dat,
    input  logic [31:0] ld_pull,
    input  logic        req,
    input  logic        we,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic [31:0] cfg_q,
    output logic [31:0] dat_q,
    output logic [31:0] pull_q,
    output logic [40:0] lg [8],
    output logic [3:0]  lg_n
);
    always_comb begin
        case (addr)
            8'h00:   rdata = cfg_q;
            8'h04:   rdata = dat_q;
            8'h08:   rdata = pull_q;
            default: rdata = 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lg_n <= '0;
            for (int i = 0; i < 8; i++) lg[i] <= '0;
        end else if (req) begin
            if (lg_n < 4'd8) lg[lg_n[2:0]] <= {we, addr, wdata};
            lg_n <= lg_n + 4'd1;
        end
        if (rst) begin
            cfg_q  <= '0;
            dat_q  <= '0;
            pull_q <= '0;
        end else if (load) begin
            cfg_q  <= ld_cfg;
            dat_q  <= ld_dat;
            pull_q <= ld_pull;
        end else if (req && we) begin
            case (addr)
                8'h00: cfg_q  <= wdata;
                8'h04: dat_q  <= wdata;
                8'h08: pull_q <= wdata;
                default: ;
            endcase
        end
    end
endmodule

module tb_gpio_restore_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [1:0]  sreq = '0, rreq = '0, clr = '0, load = '0;
    logic [1:0]  busy, done, breq, bwe;
    logic [7:0]  baddr [2];
    logic [31:0] bwdata [2], brdata [2];
    logic [31:0] ld_cfg = '0, ld_dat = '0, ld_pull = '0;
    logic [31:0] cfg_q [2], dat_q [2], pull_q [2];
    logic [40:0] lg0 [8], lg1 [8];
    logic [3:0]  lgn [2];

    int n_chk = 0;
    int n_fail = 0;

    gpio_restore_seq #(.FIELD_W(2)) dut (
        .clk(clk), .rst(rst), .save_req(sreq[0]), .restore_req(rreq[0]),
        .busy(busy[0]), .done(done[0]), .bus_req(breq[0]), .bus_we(bwe[0]),
        .bus_addr(baddr[0]), .bus_wdata(bwdata[0]), .bus_rdata(brdata[0]));

    gpio_restore_seq #(.FIELD_W(4)) dut4 (
        .clk(clk), .rst(rst), .save_req(sreq[1]), .restore_req(rreq[1]),
        .busy(busy[1]), .done(done[1]), .bus_req(breq[1]), .bus_we(bwe[1]),
        .bus_addr(baddr[1]), .bus_wdata(bwdata[1]), .bus_rdata(brdata[1]));

    tb_gpio_bank bank0 (
        .clk(clk), .rst(rst), .clr(clr[0]), .load(load[0]), .ld_cfg(ld_cfg),
        .ld_dat(ld_dat), .ld_pull(ld_pull), .req(breq[0]), .we(bwe[0]),
        .addr(baddr[0]), .wdata(bwdata[0]), .rdata(brdata[0]), .cfg_q(cfg_q[0]),
        .dat_q(dat_q[0]), .pull_q(pull_q[0]), .lg(lg0), .lg_n(lgn[0]));

    tb_gpio_bank bank1 (
        .clk(clk), .rst(rst), .clr(clr[1]), .load(load[1]), .ld_cfg(ld_cfg),
        .ld_dat(ld_dat), .ld_pull(ld_pull), .req(breq[1]), .we(bwe[1]),
        .addr(baddr[1]), .wdata(bwdata[1]), .rdata(brdata[1]), .cfg_q(cfg_q[1]),
        .dat_q(dat_q[1]), .pull_q(pull_q[1]), .lg(lg1), .lg_n(lgn[1]));

    // {saved cfg, saved dat, saved pull, present cfg, present dat, expected merged cfg}
    localparam logic [31:0] VEC [5][6] = '{
        '{32'h0003_4D24, 32'hA5A5_0F0F, 32'h0000_FFFF, 32'h0002_E540, 32'h5A5A_F0F0, 32'h0002_CD20},
        '{32'h1234_5678, 32'h0000_0001, 32'h0000_0002, 32'h1234_5678, 32'h0000_0000, 32'h1234_5678},
        '{32'hAAAA_AAAA, 32'hFFFF_0000, 32'h0000_0003, 32'h0000_0000, 32'hFFFF_FFFF, 32'hAAAA_AAAA},
        '{32'h0000_0000, 32'h0000_FFFF, 32'h0000_0004, 32'h5555_5555, 32'hFFFF_0000, 32'h0000_0000},
        '{32'h5555_5555, 32'h1234_5678, 32'h0000_0005, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF}
    };

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%08h expected=%08h", rq, what, act, exp);
        end
    endtask

    function automatic logic [40:0] entry(int v, int i);
        return (v == 0) ? lg0[i] : lg1[i];
    endfunction

    task automatic preload(int v, logic [31:0] c, logic [31:0] d, logic [31:0] p);
        @(negedge clk);
        ld_cfg = c; ld_dat = d; ld_pull = p;
        load[v] = 1'b1;
        @(negedge clk);
        load[v] = 1'b0;
    endtask

    // issue one request (save, restore or both) and count cycles to done
    task automatic run_op(int v, bit do_save, bit do_rest, bit poke, output int cyc);
        @(negedge clk);
        clr[v] = 1'b1;
        @(negedge clk);
        clr[v] = 1'b0;
        sreq[v] = do_save;
        rreq[v] = do_rest;
        cyc = 0;
        while (cyc < 40) begin
            @(negedge clk);
            sreq[v] = 1'b0;
            rreq[v] = 1'b0;
            cyc++;
            if (poke && cyc == 2) begin
                sreq[v] = 1'b1;
                rreq[v] = 1'b1;
            end
            if (done[v]) break;
        end
    endtask

    // replay the write log pin by pin and judge mode ordering
    task automatic glitch_check(int v, logic [31:0] cur, logic [31:0] sav, string tag);
        int fw = (v == 0) ? 2 : 4;
        int nf = 32 / fw;
        int scan = (v == 0) ? 16 : 4;
        logic [31:0] prev = cur;
        bit dat_seen = 0;
        bit bad_mid = 0;
        bit bad_order = 0;
        for (int e = 0; e < int'(lgn[v]) && e < 8; e++) begin
            logic [40:0] en = entry(v, e);
            if (en[40] && en[39:32] == 8'h04) dat_seen = 1;
            if (en[40] && en[39:32] == 8'h00) begin
                for (int f = 0; f < nf; f++) begin
                    int fo = int'((cur >> (f*fw)) & ((1 << fw) - 1));
                    int fn = int'((sav >> (f*fw)) & ((1 << fw) - 1));
                    int fp = int'((prev >> (f*fw)) & ((1 << fw) - 1));
                    int fx = int'((en[31:0] >> (f*fw)) & ((1 << fw) - 1));
                    if (fx != fo && fx != fn) bad_mid = 1;
                    if (fx != fp) begin
                        if (fn == 1 && fo != 1 && !dat_seen) bad_order = 1;
                        if (f < scan && fn != 1 && !(fo >= 2 && fn >= 2) && dat_seen) bad_order = 1;
                    end
                end
                prev = en[31:0];
            end
        end
        chk(!bad_mid, "R8", {tag, " no intermediate mode"}, {31'd0, bad_mid}, 32'd0);
        chk(!bad_order, "R8", {tag, " mode change vs data order"}, {31'd0, bad_order}, 32'd0);
    endtask

    task automatic restore_case(int v, logic [31:0] sc, logic [31:0] sd, logic [31:0] sp,
                                logic [31:0] cc, logic [31:0] cd, logic [31:0] merged,
                                bit poke, string tag);
        int cyc;
        logic [40:0] exp [6];
        int ne;
        preload(v, sc, sd, sp);
        run_op(v, 1'b1, 1'b0, 1'b0, cyc);
        chk(cyc == 4, "R2", {tag, " save latency"}, cyc, 4);
        chk(lgn[v] == 4'd3, "R2", {tag, " save op count"}, 32'(lgn[v]), 3);
        chk(entry(v,0)[40:32] == 9'h000 && entry(v,1)[40:32] == 9'h004 &&
            entry(v,2)[40:32] == 9'h008, "R2", {tag, " save read order"},
            {23'd0, entry(v,2)[40:32]}, 32'h8);
        preload(v, cc, cd, ~sp);
        run_op(v, 1'b0, 1'b1, poke, cyc);
        if (v == 0) begin
            ne = 5;
            exp[0] = {1'b0, 8'h00, 32'h0};
            exp[1] = {1'b1, 8'h08, sp};
            exp[2] = {1'b1, 8'h00, merged};
            exp[3] = {1'b1, 8'h04, sd};
            exp[4] = {1'b1, 8'h00, sc};
            chk(cyc == 6, "R9", {tag, " restore latency"}, cyc, 6);
        end else begin
            ne = 6;
            exp[0] = {1'b0, 8'h00, 32'h0};
            exp[1] = {1'b1, 8'h00, merged};
            exp[2] = {1'b1, 8'h04, sd};
            exp[3] = {1'b1, 8'h00, sc};
            exp[4] = {1'b1, 8'h04, sd};
            exp[5] = {1'b1, 8'h08, sp};
            chk(cyc == 7, "R9", {tag, " restore latency"}, cyc, 7);
        end
        chk(int'(lgn[v]) == ne, (v == 0) ? "R6" : "R7", {tag, " op count"}, 32'(lgn[v]), ne);
        for (int e = 0; e < ne; e++) begin
            logic [40:0] got = entry(v, e);
            bit ok = (e == 0) ? (got[40:32] == exp[0][40:32]) : (got == exp[e]);
            chk(ok, (v == 0) ? "R6" : "R7", $sformatf("%s op %0d", tag, e),
                got[31:0], exp[e][31:0]);
        end
        chk(entry(v,2 - v)[31:0] == merged, "R4", {tag, " change mask merge"},
            entry(v, 2 - v)[31:0], merged);
        chk(cfg_q[v] == sc && dat_q[v] == sd && pull_q[v] == sp, "R11",
            {tag, " bank ends at saved state"}, cfg_q[v], sc);
        glitch_check(v, cc, sc, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 2'b00 && done == 2'b00 && breq == 2'b00, "R1", "reset state",
            {26'd0, busy, done, breq}, 32'd0);
        repeat (3) @(negedge clk);
        chk(breq == 2'b00, "R1", "idle bus quiet", {30'd0, breq}, 32'd0);

        // R3 R4 R5: vector 0 covers all nine present/saved mode pairs
        for (int k = 0; k < 5; k++) begin
            restore_case(0, VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3], VEC[k][4],
                         VEC[k][5], 1'b0, $sformatf("R3 R5 vec%0d", k));
        end

        // R7: 4-bit variant, upper fields outside the scan stay in place early
        restore_case(1, 32'h0000_1105, 32'hCAFE_0001, 32'h0000_0077,
                     32'h1111_7010, 32'h0, 32'h1111_7005, 1'b0, "R7 wide");

        // R10: requests during a restore are ignored
        restore_case(0, VEC[0][0], VEC[0][1], VEC[0][2], VEC[0][3], VEC[0][4],
                     VEC[0][5], 1'b1, "R10 busy poke");
        repeat (2) @(negedge clk);
        chk(busy[0] == 1'b0, "R10", "no queued start", {31'd0, busy[0]}, 32'd0);

        // R10: simultaneous save and restore picks save
        preload(0, 32'h0, 32'h0, 32'h0);
        run_op(0, 1'b1, 1'b1, 1'b0, cyc);
        chk(cyc == 4 && lgn[0] == 4'd3 && entry(0,0)[40] == 1'b0 && entry(0,1)[40] == 1'b0 &&
            entry(0,2)[40] == 1'b0, "R10", "save wins tie", cyc, 4);
        @(negedge clk);
        chk(done[0] == 1'b0, "R9", "done one cycle", {31'd0, done[0]}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule